// File: doc/BRIEF.md
# Packed Lane Permute Unit

This unit rearranges 32-bit lanes taken from two 128-bit operands, called the destination and the source. A 3-bit opcode picks one of six operations: a shuffle steered by an 8-bit immediate, two interleaves, two half-register moves, and a sign-mask extraction. The result is always a new 128-bit value. The mask extraction also yields a 32-bit mask.

A caller presents both operands, the opcode and the immediate together with an input valid strobe. One clock later the registered result, the mask and an output valid strobe appear. While the input strobe is low the output registers keep their last values. There is no stall and no back-pressure, so an operation can be issued on every clock.

Unit states and transitions: the output stage has two named conditions.
- IDLE: out_valid is low.
- EMIT: out_valid is high.

The stage moves IDLE→EMIT when in_valid is sampled high. It moves EMIT→IDLE when in_valid is sampled low. It stays in EMIT on back-to-back issue.

Top module: `lane_perm_top`

## Requirements
- R1: While rst_n is low, out_valid, out_result and out_mask are all zero.
- R2: out_valid equals the value in_valid had at the previous rising clock edge.
- R3: Opcode 0 (shuffle) takes result lane 0 from destination lane imm[1:0] and result lane 1 from destination lane imm[3:2]. Lane k occupies bits 32k+31:32k.
- R4: Opcode 0 takes result lane 2 from source lane imm[5:4] and result lane 3 from source lane imm[7:6].
- R5: Opcode 1 (low interleave) gives result lanes 0 to 3 as destination lane 0, source lane 0, destination lane 1, source lane 1.
- R6: Opcode 2 (high interleave) gives result lanes 0 to 3 as destination lane 2, source lane 2, destination lane 3, source lane 3.
- R7: Opcode 3 (high-to-low move) puts source bits 127:64 into result bits 63:0 and keeps destination bits 127:64 in result bits 127:64.
- R8: Opcode 4 (low-to-high move) puts source bits 63:0 into result bits 127:64 and keeps destination bits 63:0 in result bits 63:0.
- R9: Opcode 5 (sign mask) places source bits 31, 63, 95 and 127 into mask bits 0, 1, 2 and 3, with mask bits 31:4 zero. The result equals the destination.
- R10: Every opcode other than 5 leaves the mask at zero.
- R11: Opcodes 6 and 7 return the destination unchanged.
- R12: While in_valid is low, out_result and out_mask hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 3 | Operation code |
| in_imm | input | 8 | Shuffle lane selectors |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_result | output | 128 | Rearranged lanes |
| out_mask | output | 32 | Zero-extended sign mask |

## Verification
Two functions can meet at the mask output in adjacent cycles. A sign-mask operation can be issued back to back with a shuffle or a move, so one cycle must present a non-zero mask and the very next cycle must clear it to zero. The bench provokes this by issuing such pairs with no gap, using sources whose lanes all have their sign bit set. It judges every emitted result and mask against an independent model held in a scoreboard. The bench also exercises a hold window in which the inputs change while the strobe is low, and checks that nothing moves during it.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF    = 3'd0,
        OP_ILO     = 3'd1,
        OP_IHI     = 3'd2,
        OP_HTOL    = 3'd3,
        OP_LTOH    = 3'd4,
        OP_SGNMASK = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } perm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned SEL_W  = $clog2(LANES),
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) lane = vec[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/lane_interleave.sv
module lane_interleave #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned HALF_L = LANES / 2
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] lo_mix,
    output logic [DATA_W-1:0] hi_mix
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned PAIR = i / 2;
        if ((i % 2) == 0) begin : g_even
            assign lo_mix[i*LANE_W +: LANE_W] = dst[PAIR*LANE_W +: LANE_W];
            assign hi_mix[i*LANE_W +: LANE_W] = dst[(HALF_L+PAIR)*LANE_W +: LANE_W];
        end else begin : g_odd
            assign lo_mix[i*LANE_W +: LANE_W] = src[PAIR*LANE_W +: LANE_W];
            assign hi_mix[i*LANE_W +: LANE_W] = src[(HALF_L+PAIR)*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/lane_sign_mask.sv
module lane_sign_mask #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned MASK_W = 32,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] vec,
    output logic [MASK_W-1:0] mask
);
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        if (i < LANES) begin : g_sign
            assign mask[i] = vec[i*LANE_W + LANE_W - 1];
        end else begin : g_zero
            assign mask[i] = 1'b0;
        end
    end
endmodule

// File: rtl/lane_perm_top.sv
module lane_perm_top
    import lane_perm_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned MASK_W = 32,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned SEL_W  = $clog2(LANES),
    localparam int unsigned IMM_W  = SEL_W * LANES,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [MASK_W-1:0] out_mask
);
    logic [DATA_W-1:0] shuf_vec;
    logic [DATA_W-1:0] lo_mix;
    logic [DATA_W-1:0] hi_mix;
    logic [MASK_W-1:0] sign_bits;
    logic [DATA_W-1:0] next_result;
    logic [MASK_W-1:0] next_mask;
    out_state_e        state_q;
    out_state_e        state_d;

    // Shuffle: lower half of the lanes from the destination, upper half from the source
    for (genvar i = 0; i < LANES; i++) begin : g_shuf
        if (i < LANES / 2) begin : g_from_dst
            lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
                .vec  (in_dst),
                .sel  (in_imm[i*SEL_W +: SEL_W]),
                .lane (shuf_vec[i*LANE_W +: LANE_W])
            );
        end else begin : g_from_src
            lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
                .vec  (in_src),
                .sel  (in_imm[i*SEL_W +: SEL_W]),
                .lane (shuf_vec[i*LANE_W +: LANE_W])
            );
        end
    end

    lane_interleave #(.LANE_W(LANE_W), .LANES(LANES)) u_mix (
        .dst    (in_dst),
        .src    (in_src),
        .lo_mix (lo_mix),
        .hi_mix (hi_mix)
    );

    lane_sign_mask #(.LANE_W(LANE_W), .LANES(LANES), .MASK_W(MASK_W)) u_sgn (
        .vec  (in_src),
        .mask (sign_bits)
    );

    always_comb begin
        next_mask = '0;
        unique case (perm_op_e'(in_op))
            OP_SHUF:    next_result = shuf_vec;
            OP_ILO:     next_result = lo_mix;
            OP_IHI:     next_result = hi_mix;
            OP_HTOL:    next_result = {in_dst[DATA_W-1:HALF_W], in_src[DATA_W-1:HALF_W]};
            OP_LTOH:    next_result = {in_src[HALF_W-1:0], in_dst[HALF_W-1:0]};
            OP_SGNMASK: begin
                next_result = in_dst;
                next_mask   = sign_bits;
            end
            OP_RSV6, OP_RSV7: next_result = in_dst;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_mask   <= '0;
        end else if (in_valid) begin
            out_result <= next_result;
            out_mask   <= next_mask;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/lane_perm_chk.sv
module lane_perm_chk #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned MASK_W = 32,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [DATA_W-1:0] in_dst,
    input logic [DATA_W-1:0] in_src,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [MASK_W-1:0] out_mask
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[MASK_W-1:LANES] == '0);

    // R9
    mask_signs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5) |=>
        out_mask[3:0] == {$past(in_src[4*LANE_W-1]), $past(in_src[3*LANE_W-1]),
                          $past(in_src[2*LANE_W-1]), $past(in_src[LANE_W-1])});

    // R10
    mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 3'd5) |=> out_mask == '0);

    // R11
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b11) |=> out_result == $past(in_dst));

    // R12
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_mask)));
endmodule

bind lane_perm_top lane_perm_chk #(.LANE_W(LANE_W), .LANES(LANES), .MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_dst     (in_dst),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_mask   (out_mask)
);

// File: tb/sim_lane_perm_top.sv
module sim_lane_perm_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [7:0]   in_imm = '0;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic [31:0]  out_mask;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [127:0] res;
        logic [31:0]  msk;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_seen;
    bit   have_last = 1'b0;
    bit   mon_on = 1'b0;

    always #2.5 clk = ~clk;

    lane_perm_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src),
        .out_valid(out_valid), .out_result(out_result), .out_mask(out_mask)
    );

    function automatic logic [31:0] ln(input logic [127:0] x, input int i);
        return x[i*32 +: 32];
    endfunction

    function automatic exp_t model(input logic [2:0] op, input logic [7:0] imm,
                                   input logic [127:0] d, input logic [127:0] s);
        exp_t e;
        e.msk = '0;
        case (op)
            3'd0: e.res = {ln(s, int'(imm[7:6])), ln(s, int'(imm[5:4])),
                           ln(d, int'(imm[3:2])), ln(d, int'(imm[1:0]))};
            3'd1: e.res = {ln(s, 1), ln(d, 1), ln(s, 0), ln(d, 0)};
            3'd2: e.res = {ln(s, 3), ln(d, 3), ln(s, 2), ln(d, 2)};
            3'd3: e.res = {d[127:64], s[127:64]};
            3'd4: e.res = {s[63:0], d[63:0]};
            3'd5: begin
                e.res = d;
                e.msk = {28'd0, s[127], s[95], s[63], s[31]};
            end
            default: e.res = d;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] ar,
                         input logic [31:0] am, input logic [127:0] er, input logic [31:0] em);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got result=%h mask=%h expected result=%h mask=%h",
                     tag, ar, am, er, em);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [7:0] imm,
                        input logic [127:0] d, input logic [127:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_op = op;
        in_imm = imm;
        in_dst = d;
        in_src = s;
        e = model(op, imm, d, s);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op = 3'(k + 5);
            in_imm = ~in_imm;
            in_dst = ~in_dst;
            in_src = {in_src[0], in_src[127:1]} ^ 128'hFFFF_FFFF_0000_0000_8000_0000_8000_0000;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected out_valid", out_result, out_mask, '0, '0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(out_result === e.res && out_mask === e.msk, e.tag,
                              out_result, out_mask, e.res, e.msk);
                        last_seen = e;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check(out_result === last_seen.res && out_mask === last_seen.msk,
                          "R12 hold while idle", out_result, out_mask, last_seen.res, last_seen.msk);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(5ns * 20000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [127:0] da, sa, sneg, smix;
        da   = {32'hD3D3_D3D3, 32'hD2D2_D2D2, 32'hD1D1_D1D1, 32'hD0D0_D0D0};
        sa   = {32'h5353_5353, 32'h5252_5252, 32'h5151_5151, 32'h5050_5050};
        sneg = {32'hF000_0003, 32'h8000_0002, 32'hC000_0001, 32'h9000_0000};
        smix = {32'h0000_0004, 32'h8000_0003, 32'h7FFF_FFFF, 32'h8000_0001};

        in_op = 3'd5; in_src = sneg; in_dst = da; in_imm = 8'hFF;
        repeat (2) @(negedge clk);
        // R1: reset values while rst_n is low, inputs active
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_result === '0 && out_mask === '0, "R1 reset state",
              out_result, out_mask, '0, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R3 R4: shuffle with several immediates
        send(3'd0, 8'h00, da, sa, "R3 R4 shuffle imm 00");
        send(3'd0, 8'hFF, da, sa, "R3 R4 shuffle imm FF");
        send(3'd0, 8'h1B, da, sa, "R3 R4 shuffle imm 1B");
        send(3'd0, 8'hE4, da, sa, "R3 R4 shuffle imm E4");
        send(3'd0, 8'h4E, sa, da, "R3 R4 shuffle imm 4E swapped");
        // R5 R6: interleaves
        send(3'd1, 8'h00, da, sa, "R5 low interleave");
        send(3'd2, 8'h00, da, sa, "R6 high interleave");
        send(3'd1, 8'hAA, sa, da, "R5 low interleave swapped");
        send(3'd2, 8'h55, sa, da, "R6 high interleave swapped");
        // R7 R8: half moves
        send(3'd3, 8'h00, da, sa, "R7 high-to-low move");
        send(3'd4, 8'h00, da, sa, "R8 low-to-high move");
        idle(3);
        // R9 R10: mask then immediately non-mask op, back to back
        send(3'd5, 8'h00, da, sneg, "R9 sign mask all negative");
        send(3'd0, 8'h1B, da, sneg, "R10 shuffle clears mask");
        send(3'd5, 8'h00, da, smix, "R9 sign mask mixed");
        send(3'd3, 8'h00, da, sneg, "R10 move clears mask");
        send(3'd5, 8'h00, sa, sa, "R9 sign mask none set");
        send(3'd5, 8'h00, da, sneg, "R9 sign mask again");
        send(3'd4, 8'h00, da, sneg, "R10 low-to-high clears mask");
        // R11: reserved opcodes
        send(3'd6, 8'h1B, da, sneg, "R11 opcode 6 passes destination");
        send(3'd7, 8'hE4, sa, sneg, "R11 opcode 7 passes destination");
        // R12: hold across idle window with changing inputs
        send(3'd5, 8'h00, da, smix, "R9 mask before idle");
        idle(4);
        send(3'd2, 8'h00, sneg, smix, "R6 after idle");
        idle(3);

        if (exp_q.size() != 0)
            check(1'b0, "R2 missing results", '0, '0, '0, 32'(exp_q.size()));
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule